// File: doc/BRIEF.md
# Synchronous DRAM Burst Engine with Byte-Lane Write Masking

This block is a cycle-accurate behavioural model of the data path of a small two-bank, 16-bit synchronous DRAM. A controller presents already-decoded commands on a 3-bit command input: mode load, row open, read, write and bank close. Data comes in on `dq_in` and goes out on `dq_out`. The bidirectional data bus is split into these two directions, and `dq_oe` marks the cycles in which the model drives read data. The array behind the model is a small register array whose size is set by parameters.

Every read or write takes its first column from the command. The following beats come from an internal column counter that wraps inside an aligned block the size of the burst. Each of the two byte lanes can be muted during any write beat. Muting acts in the same cycle as the data and never stops the column counter. A mode bit turns every write into a single-word operation while reads keep the full burst. Read data returns after a programmed latency of two or three cycles.

Top module: `sdram_burst_model`

## Requirements
- R1: A mode-load command (cmd=1) latches its fields from `addr`. Bits 2:0 set the burst length: code 0 gives 1, code 1 gives 2, code 2 gives 4, and codes 3 to 7 give 8. Bit 3 is ignored, since ordering is always sequential. Bits 6:4 set the read latency: the value 3 selects 3 cycles and any other value selects 2. Bit 9 set selects single-word writes. After reset the mode is burst length 1, latency 2, burst writes.
- R2: A row-open command (cmd=2) stores `addr[ROW_W-1:0]` as the open row of the bank named by `bank`. A bank-close command (cmd=5) closes that bank. A read (cmd=3) or write (cmd=4) to a closed bank performs no access and raises `addr_err` for exactly the one cycle that follows the edge that sampled it.
- R3: A write stores its first word at the column `addr[COL_W-1:0]` in the command cycle. The next length-1 cycles store words at the following columns. Only the low log2(length) column bits count, wrapping inside the aligned block, and the upper column bits are held.
- R4: `lane_mask[1]` high blocks `dq_in[15:8]` and `lane_mask[0]` high blocks `dq_in[7:0]` on the write beat of that same cycle. Each lane is masked independently and a blocked lane keeps its old contents.
- R5: A masked beat still advances the column counter. Later unmasked beats land at their normal columns, and a lane is written again on the first beat its mask is low.
- R6: A read returns a burst of the programmed length in the same column order as R3. The first word is on `dq_out` with `dq_oe` high at the rising edge that comes latency edges after the edge that sampled the read, and is not there one cycle earlier. The remaining words follow on consecutive cycles.
- R7: In single-word write mode a write stores only the word of its command cycle, even when further data is presented. Reads still return the full programmed length at either latency, and masking still applies to the single word.
- R8: A read or write command ends any burst in progress. The new burst issues its first beat in that same cycle, and read words already in the latency pipeline are still delivered.
- R9: After reset, and in every cycle that carries no read word, `dq_oe` is low. `addr_err` is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Decoded command: 0 idle, 1 mode load, 2 row open, 3 read, 4 write, 5 bank close |
| bank | input | BANK_W | Bank select |
| addr | input | ADDR_W | Row for row open, column for read and write, fields for mode load |
| dq_in | input | DATA_W | Write data |
| lane_mask | input | DATA_W/8 | Per-byte write block; bit 1 blocks bits 15:8 and bit 0 blocks bits 7:0 |
| dq_out | output | DATA_W | Read data |
| dq_oe | output | 1 | High when `dq_out` carries a read word |
| addr_err | output | 1 | One-cycle flag for an access to a closed bank |

## Verification
The hardest case to reach from the ports is a burst whose start column sits in the middle of its block, so that it wraps, and whose masks switch lanes on and off between beats. Only a later read of the whole block shows whether a masked beat left its lane untouched while the counter still moved on. The bench sets up such bursts directly, with masks that are high on the early beats and low on the late ones, and the reverse. It also overlaps a second read or write with a running burst. Random rounds then mix burst length, latency, write mode, bank, row, start column and per-beat masks, and every round is read back against a shadow array.

// File: rtl/sdram_pkg.sv
package sdram_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_MODE = 3'd1,
        CMD_OPEN = 3'd2,
        CMD_RD   = 3'd3,
        CMD_WR   = 3'd4,
        CMD_CLOSE = 3'd5
    } cmd_e;

    // mode-load field positions
    localparam int LEN_LO   = 0;
    localparam int LAT_LO   = 4;
    localparam int SINGLE_B = 9;
    localparam int MODE_W   = 10;

    // deepest read latency supported
    localparam int MAX_LAT  = 3;

    typedef struct packed {
        logic [2:0] len_code;
        logic       lat3;
        logic       single;
    } mode_t;

endpackage

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
    import sdram_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MODE_W-1:0] fld,
    output logic [3:0]        burst_len,
    output logic [1:0]        cas_lat,
    output logic              single_wr
);

    mode_t mode_d, mode_q;

    logic unused_fld;
    assign unused_fld = ^{fld[3], fld[8:7]};

    always_comb begin
        mode_d = mode_q;
        if (load) begin
            mode_d.len_code = fld[LEN_LO +: 3];
            mode_d.lat3     = (fld[LAT_LO +: 3] == 3'd3);
            mode_d.single   = fld[SINGLE_B];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_d;
    end

    always_comb begin
        unique case (mode_q.len_code)
            3'd0:    burst_len = 4'd1;
            3'd1:    burst_len = 4'd2;
            3'd2:    burst_len = 4'd4;
            default: burst_len = 4'd8;
        endcase
    end

    assign cas_lat   = mode_q.lat3 ? 2'd3 : 2'd2;
    assign single_wr = mode_q.single;

endmodule

// File: rtl/sdram_bank_table.sv
module sdram_bank_table #(
    parameter int BANK_W = 1,
    parameter int ROW_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_en,
    input  logic              close_en,
    input  logic [BANK_W-1:0] bank,
    input  logic [ROW_W-1:0]  row_in,
    output logic              bank_open,
    output logic [ROW_W-1:0]  bank_row
);

    localparam int BANKS = 1 << BANK_W;

    typedef struct packed {
        logic [BANKS-1:0]            live;
        logic [BANKS-1:0][ROW_W-1:0] row;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (open_en) begin
            tbl_d.live[bank] = 1'b1;
            tbl_d.row[bank]  = row_in;
        end
        if (close_en) begin
            tbl_d.live[bank] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign bank_open = tbl_q.live[bank];
    assign bank_row  = tbl_q.row[bank];

endmodule

// File: rtl/sdram_burst_ctr.sv
module sdram_burst_ctr #(
    parameter int BANK_W = 1,
    parameter int ROW_W  = 2,
    parameter int COL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_access,
    input  logic              start_rd,
    input  logic              start_wr,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [ROW_W-1:0]  cmd_row,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic [3:0]        burst_len,
    input  logic              single_wr,
    output logic              beat_rd,
    output logic              beat_wr,
    output logic [BANK_W-1:0] beat_bank,
    output logic [ROW_W-1:0]  beat_row,
    output logic [COL_W-1:0]  beat_col
);

    typedef struct packed {
        logic              active;
        logic              is_wr;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  base;
        logic [COL_W-1:0]  wmask;
        logic [COL_W-1:0]  offset;
        logic [3:0]        left;
    } burst_t;

    burst_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        beat_rd   = 1'b0;
        beat_wr   = 1'b0;
        beat_bank = cmd_bank;
        beat_row  = cmd_row;
        beat_col  = cmd_col;
        if (cmd_access) begin
            // any new access replaces the running burst
            beat_rd     = start_rd;
            beat_wr     = start_wr;
            st_d.active = (start_rd || (start_wr && !single_wr)) && (burst_len > 4'd1);
            st_d.is_wr  = start_wr;
            st_d.bank   = cmd_bank;
            st_d.row    = cmd_row;
            st_d.base   = cmd_col;
            st_d.wmask  = COL_W'(burst_len - 4'd1);
            st_d.offset = COL_W'(1);
            st_d.left   = burst_len - 4'd1;
        end else if (st_q.active && !(st_q.is_wr && single_wr)) begin
            beat_rd     = !st_q.is_wr;
            beat_wr     = st_q.is_wr;
            beat_bank   = st_q.bank;
            beat_row    = st_q.row;
            beat_col    = (st_q.base & ~st_q.wmask) |
                          ((st_q.base + st_q.offset) & st_q.wmask);
            st_d.offset = st_q.offset + COL_W'(1);
            st_d.left   = st_q.left - 4'd1;
            st_d.active = (st_q.left > 4'd1);
        end else begin
            st_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe
    import sdram_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_rd,
    input  logic [DATA_W-1:0] rd_word,
    input  logic [1:0]        cas_lat,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    typedef struct packed {
        logic [MAX_LAT-1:0]             vld;
        logic [MAX_LAT-1:0][DATA_W-1:0] dat;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d        = pipe_q;
        pipe_d.vld[0] = beat_rd;
        pipe_d.dat[0] = rd_word;
        for (int s = 1; s < MAX_LAT; s++) begin
            pipe_d.vld[s] = pipe_q.vld[s-1];
            pipe_d.dat[s] = pipe_q.dat[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    logic [1:0] tap;
    assign tap    = cas_lat - 2'd1;
    assign dq_oe  = pipe_q.vld[tap];
    assign dq_out = pipe_q.dat[tap];

endmodule

// File: rtl/sdram_burst_model.sv
module sdram_burst_model
    import sdram_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BANK_W = 1,
    parameter int ROW_W  = 2,
    parameter int COL_W  = 4,
    parameter int ADDR_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2:0]            cmd,
    input  logic [BANK_W-1:0]     bank,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     dq_in,
    input  logic [DATA_W/8-1:0]   lane_mask,
    output logic [DATA_W-1:0]     dq_out,
    output logic                  dq_oe,
    output logic                  addr_err
);

    localparam int LANES = DATA_W / 8;
    localparam int IDX_W = BANK_W + ROW_W + COL_W;
    localparam int DEPTH = 1 << IDX_W;

    cmd_e cmd_c;
    assign cmd_c = cmd_e'(cmd);

    logic cmd_access, cmd_open, start_rd, start_wr;
    logic [ROW_W-1:0] open_row;
    logic [3:0] burst_len;
    logic [1:0] cas_lat;
    logic single_wr;

    assign cmd_access = (cmd_c == CMD_RD) || (cmd_c == CMD_WR);
    assign start_rd   = (cmd_c == CMD_RD) && cmd_open;
    assign start_wr   = (cmd_c == CMD_WR) && cmd_open;

    if (ADDR_W > MODE_W) begin : g_addr_hi
        logic unused_addr_hi;
        assign unused_addr_hi = ^addr[ADDR_W-1:MODE_W];
    end

    sdram_mode_reg u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cmd_c == CMD_MODE),
        .fld       (addr[MODE_W-1:0]),
        .burst_len (burst_len),
        .cas_lat   (cas_lat),
        .single_wr (single_wr)
    );

    sdram_bank_table #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .open_en   (cmd_c == CMD_OPEN),
        .close_en  (cmd_c == CMD_CLOSE),
        .bank      (bank),
        .row_in    (addr[ROW_W-1:0]),
        .bank_open (cmd_open),
        .bank_row  (open_row)
    );

    logic              beat_rd, beat_wr;
    logic [BANK_W-1:0] beat_bank;
    logic [ROW_W-1:0]  beat_row;
    logic [COL_W-1:0]  beat_col;

    sdram_burst_ctr #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_access (cmd_access),
        .start_rd   (start_rd),
        .start_wr   (start_wr),
        .cmd_bank   (bank),
        .cmd_row    (open_row),
        .cmd_col    (addr[COL_W-1:0]),
        .burst_len  (burst_len),
        .single_wr  (single_wr),
        .beat_rd    (beat_rd),
        .beat_wr    (beat_wr),
        .beat_bank  (beat_bank),
        .beat_row   (beat_row),
        .beat_col   (beat_col)
    );

    // storage array and per-lane write enables
    logic [DATA_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  beat_idx;
    logic [LANES-1:0]  lane_we;

    assign beat_idx = {beat_bank, beat_row, beat_col};

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        assign lane_we[ln] = beat_wr && !lane_mask[ln];
    end

    always_ff @(posedge clk) begin
        for (int ln = 0; ln < LANES; ln++) begin
            if (lane_we[ln]) mem[beat_idx][ln*8 +: 8] <= dq_in[ln*8 +: 8];
        end
    end

    sdram_rd_pipe #(.DATA_W(DATA_W)) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .beat_rd (beat_rd),
        .rd_word (mem[beat_idx]),
        .cas_lat (cas_lat),
        .dq_out  (dq_out),
        .dq_oe   (dq_oe)
    );

    // closed-bank access flag
    logic err_d, err_q;

    always_comb begin
        err_d = cmd_access && !cmd_open;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_d;
    end

    assign addr_err = err_q;

endmodule

// File: rtl/sdram_burst_model_chk.sv
module sdram_burst_model_chk
    import sdram_pkg::*;
#(
    parameter int COL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input cmd_e             cmd_c,
    input logic             cmd_open,
    input logic             beat_rd,
    input logic             beat_wr,
    input logic [COL_W-1:0] beat_col,
    input logic [1:0]       cas_lat,
    input logic             single_wr,
    input logic             dq_oe,
    input logic             addr_err
);

    AST_ERR_FOLLOWS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> ($past(cmd_c) == CMD_RD || $past(cmd_c) == CMD_WR)); // R2

    AST_CLOSED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_c == CMD_WR && !cmd_open) |-> !beat_wr); // R2

    AST_COL_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_wr && cmd_c != CMD_WR) |-> ($past(beat_wr) && beat_col[0] != $past(beat_col[0]))); // R5

    AST_SINGLE_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (single_wr && beat_wr) |-> cmd_c == CMD_WR); // R7

    AST_RD_LAT2: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_rd && cas_lat == 2'd2) |-> ##2 dq_oe); // R6

    AST_RD_LAT3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_rd && cas_lat == 2'd3) |-> ##3 dq_oe); // R6

    AST_BEAT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({beat_rd, beat_wr})); // R8

endmodule

bind sdram_burst_model sdram_burst_model_chk #(.COL_W(COL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_c     (cmd_c),
    .cmd_open  (cmd_open),
    .beat_rd   (beat_rd),
    .beat_wr   (beat_wr),
    .beat_col  (beat_col),
    .cas_lat   (cas_lat),
    .single_wr (single_wr),
    .dq_oe     (dq_oe),
    .addr_err  (addr_err)
);

// File: tb/sdram_burst_model_bench.sv
`timescale 1ns/1ps
module sdram_burst_model_bench;
    import sdram_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd = 3'd0;
    logic        bank = 1'b0;
    logic [9:0]  addr = '0;
    logic [15:0] dq_in = '0;
    logic [1:0]  lane_mask = '0;
    logic [15:0] dq_out;
    logic        dq_oe, addr_err;

    always #2.5 clk = ~clk;

    sdram_burst_model u_sdram_burst_model (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .addr(addr),
        .dq_in(dq_in), .lane_mask(lane_mask), .dq_out(dq_out),
        .dq_oe(dq_oe), .addr_err(addr_err)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [15:0] shadow [128];
    int   cur_bl = 1, cur_cl = 2;
    bit   cur_single = 0;
    bit   open_v [2];
    int   open_r [2];
    logic [15:0] wd [8];
    logic [1:0]  wm [8];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input cmd_e c, input logic b, input logic [9:0] a,
                         input logic [15:0] d, input logic [1:0] m);
        @(negedge clk);
        cmd = c; bank = b; addr = a; dq_in = d; lane_mask = m;
    endtask

    function automatic int bcol(input int start, input int k, input int bl);
        return (start & ~(bl - 1)) | ((start + k) & (bl - 1));
    endfunction

    function automatic int sidx(input int b, input int r, input int c);
        return b * 64 + r * 16 + c;
    endfunction

    task automatic shadow_put(input int b, input int c, input logic [15:0] d, input logic [1:0] m);
        int i = sidx(b, open_r[b], c);
        if (!m[1]) shadow[i][15:8] = d[15:8];
        if (!m[0]) shadow[i][7:0]  = d[7:0];
    endtask

    task automatic mode(input int code, input int lat, input bit single);
        drive(CMD_MODE, 1'b0, {single, 2'b00, 3'(lat), 1'b0, 3'(code)}, '0, '0);
        cur_bl = (code >= 3) ? 8 : (1 << code);
        cur_cl = (lat == 3) ? 3 : 2;
        cur_single = single;
    endtask

    task automatic act(input logic b, input int r);
        drive(CMD_OPEN, b, 10'(r), '0, '0);
        open_v[b] = 1; open_r[b] = r;
    endtask

    task automatic wr_burst(input logic b, input int col);
        for (int k = 0; k < cur_bl; k++) begin
            drive(k == 0 ? CMD_WR : CMD_NOP, b, 10'(col), wd[k], wm[k]);
            if (open_v[b] && (!cur_single || k == 0)) shadow_put(b, bcol(col, k, cur_bl), wd[k], wm[k]);
        end
    endtask

    task automatic rd_burst(input logic b, input int col, input string req);
        drive(CMD_RD, b, 10'(col), '0, '0);
        drive(CMD_NOP, 1'b0, '0, '0, '0);
        repeat (cur_cl - 2) @(negedge clk);
        chk({req, " R6 no early data"}, dq_oe, 1'b0);
        for (int k = 0; k < cur_bl; k++) begin
            @(negedge clk);
            chk({req, " R6 oe"}, dq_oe, 1'b1);
            chk({req, " R6 word"}, dq_out, shadow[sidx(b, open_r[b], bcol(col, k, cur_bl))]);
        end
        @(negedge clk);
        chk({req, " R9 oe idle"}, dq_oe, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset oe", dq_oe, 1'b0);
        chk("R9 reset err", addr_err, 1'b0);

        // R1 reset mode: burst length 1, latency 2
        act(0, 0);
        wd[0] = 16'h1357; wm[0] = 2'b00;
        wr_burst(0, 3);
        rd_burst(0, 3, "R1 reset mode");

        // fill every location with known data
        mode(3, 2, 0);
        for (int b = 0; b < 2; b++)
            for (int r = 0; r < 4; r++) begin
                act(b[0], r);
                for (int blk = 0; blk < 2; blk++) begin
                    for (int k = 0; k < 8; k++) begin wd[k] = 16'($urandom); wm[k] = 2'b00; end
                    wr_burst(b[0], blk * 8);
                end
            end

        // R3 R4 R5: wrapping burst with mixed masks
        mode(2, 2, 0);
        act(0, 1);
        wd[0] = 16'hA0A0; wd[1] = 16'hA1A1; wd[2] = 16'hA2A2; wd[3] = 16'hA3A3;
        wm[0] = 2'b00;    wm[1] = 2'b10;    wm[2] = 2'b01;    wm[3] = 2'b11;
        wr_burst(0, 5);
        rd_burst(0, 5, "R3 R4 wrap masks");
        rd_burst(0, 4, "R4 aligned view");
        wd[0] = 16'hB0B0; wd[1] = 16'hB1B1; wd[2] = 16'hB2B2; wd[3] = 16'hB3B3;
        wm[0] = 2'b11;    wm[1] = 2'b11;    wm[2] = 2'b00;    wm[3] = 2'b00;
        wr_burst(0, 2);
        rd_burst(0, 0, "R5 resume after mask");

        // R6 latency 3 in burst-write mode
        mode(2, 3, 0);
        rd_burst(0, 5, "R6 latency3");

        // R7 single-word writes, both latencies
        mode(2, 3, 1);
        for (int k = 0; k < 8; k++) begin wd[k] = 16'hC000 + 16'(k); wm[k] = 2'b00; end
        wr_burst(0, 9);
        rd_burst(0, 8, "R7 single lat3");
        mode(2, 2, 1);
        wd[0] = 16'hD1D2; wm[0] = 2'b01;
        wr_burst(0, 10);
        rd_burst(0, 8, "R7 single lat2 masked");
        mode(3, 2, 1);
        rd_burst(0, 8, "R7 single reads full");

        // R8 write truncated by a new write
        mode(2, 2, 0);
        drive(CMD_WR, 1'b0, 10'd4, 16'hE0E0, 2'b00);  shadow_put(0, 4, 16'hE0E0, 2'b00);
        drive(CMD_NOP, 1'b0, 10'd0, 16'hE1E1, 2'b00); shadow_put(0, 5, 16'hE1E1, 2'b00);
        drive(CMD_WR, 1'b0, 10'd8, 16'hF0F0, 2'b00);  shadow_put(0, 8, 16'hF0F0, 2'b00);
        drive(CMD_NOP, 1'b0, 10'd0, 16'hF1F1, 2'b00); shadow_put(0, 9, 16'hF1F1, 2'b00);
        drive(CMD_NOP, 1'b0, 10'd0, 16'hF2F2, 2'b00); shadow_put(0, 10, 16'hF2F2, 2'b00);
        drive(CMD_NOP, 1'b0, 10'd0, 16'hF3F3, 2'b00); shadow_put(0, 11, 16'hF3F3, 2'b00);
        rd_burst(0, 4, "R8 write truncated");
        rd_burst(0, 8, "R8 new write burst");

        // R8 read truncated by a new read
        drive(CMD_RD, 1'b0, 10'd0, '0, '0);
        drive(CMD_NOP, 1'b0, '0, '0, '0);
        drive(CMD_RD, 1'b0, 10'd8, '0, '0);
        chk("R8 first word", dq_out, shadow[sidx(0, 1, 0)]);
        drive(CMD_NOP, 1'b0, '0, '0, '0);
        chk("R8 second word", dq_out, shadow[sidx(0, 1, 1)]);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R8 new burst oe", dq_oe, 1'b1);
            chk("R8 new burst word", dq_out, shadow[sidx(0, 1, 8 + k)]);
        end
        @(negedge clk);
        chk("R8 idle after", dq_oe, 1'b0);

        // R2 closed-bank access
        drive(CMD_CLOSE, 1'b1, '0, '0, '0);
        open_v[1] = 0;
        drive(CMD_WR, 1'b1, 10'd0, 16'hDEAD, 2'b00);
        drive(CMD_NOP, 1'b0, '0, 16'hBEEF, 2'b00);
        chk("R2 err pulse", addr_err, 1'b1);
        drive(CMD_NOP, 1'b0, '0, '0, '0);
        chk("R2 err one cycle", addr_err, 1'b0);
        drive(CMD_RD, 1'b1, 10'd0, '0, '0);
        for (int k = 0; k < 5; k++) begin
            drive(CMD_NOP, 1'b0, '0, '0, '0);
            if (k == 0) chk("R2 read err", addr_err, 1'b1);
            chk("R2 no read data", dq_oe, 1'b0);
        end
        act(1, open_r[1]);
        rd_burst(1, 0, "R2 array untouched");

        // R1 odd field values: length code 6 gives 8, latency field 5 gives 2
        drive(CMD_MODE, 1'b0, {1'b0, 2'b00, 3'd5, 1'b1, 3'd6}, '0, '0);
        cur_bl = 8; cur_cl = 2; cur_single = 0;
        rd_burst(1, 3, "R1 decode");

        // random rounds
        for (int it = 0; it < 60; it++) begin
            int code = $urandom % 4;
            int lat  = ($urandom % 2) ? 3 : 2;
            bit sgl  = 1'($urandom % 2);
            logic b  = 1'($urandom);
            int r    = $urandom % 4;
            int c    = $urandom % 16;
            mode(code, lat, sgl);
            act(b, r);
            for (int k = 0; k < 8; k++) begin wd[k] = 16'($urandom); wm[k] = 2'($urandom); end
            wr_burst(b, c);
            rd_burst(b, c, "R3 R4 R5 R7 random");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule